// File: doc/BRIEF.md
# SPI Register Bridge

This block is an SPI target (mode 0) that lets an external host read and write a bank of 32-bit registers. Every transaction starts with one 32-bit command word. The command carries a 16-bit start address, a read or write opcode, an auto-increment flag and a burst word count. After the command, data words stream back to back, most significant bit first, until chip select rises. On a write the host shifts the words in. On a read the bridge shifts them out on MISO, starting on the bit right after the command.

SCLK, MOSI and chip select are brought into the system clock through a synchronizer. The system clock must run at least four times faster than SCLK. On the register side the bridge is a plain synchronous master. It raises a one-cycle write strobe with address and data, or a one-cycle read strobe, and it samples read data in that same cycle. There is no back-pressure: the register bank must complete every access in the strobe cycle. A fixed identification word is answered by the bridge itself, so the host can detect that a board is present and can spot a one-bit shift on MISO.

Top module: `spi_regbus_bridge`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso` is 0 and neither `bus_wr` nor `bus_rd` is asserted.
- R2: The command word carries the address in bits 31..16, the opcode in bits 15..12 (0xA read, 0xB write), the increment flag in bit 11 and the word count (0 to 127) in bits 10..4. Bits 3..0 are ignored.
- R3: On a write, each 32 data bits after the command, MSB first, produce exactly one `bus_wr` pulse. The pulse carries the current address and the assembled word. `bus_wr` and `bus_rd` are never asserted together.
- R4: With the increment flag set, the address advances by `ADDR_STEP` after each data word. With the flag clear, every word uses the start address.
- R5: On a read, MISO presents data bit 31 of the first word on the bit right after the command. Each word is sent MSB first. MISO changes only after a falling SCLK edge, or when chip select rises.
- R6: Exactly `count` data words are transferred. Further write words cause no access, and further read words return 0. A count of 0 causes no access.
- R7: A command whose opcode is neither 0xA nor 0xB causes no bus access and keeps MISO at 0 until chip select rises.
- R8: Raising chip select discards any partial word. The next frame's first 32 bits are decoded as a fresh command.
- R9: A read at `ID_ADDR` returns `ID_WORD` and does not assert `bus_rd`.
- R10: Each read word other than the identification word causes exactly one `bus_rd` pulse, issued before that word's first bit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 32 | Register write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid in the `bus_rd` cycle |

## Verification
The hardest situation to reach is a frame that goes on past its word count, or that stops partway through a word. The host never sees any internal state that tells it the bridge has stopped counting. The stimulus therefore sends frames with more data words than the command asks for, and a frame cut off after 20 bits. The effect is then observed at the ports: no extra write strobes appear, surplus read words come back as zeros, and a clean write follows the aborted frame. A 127-word read of the identification address exercises the largest count the field can hold, and a single extra word after it must return zero.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 7;
  localparam logic [3:0] OPC_READ  = 4'hA;
  localparam logic [3:0] OPC_WRITE = 4'hB;

  typedef enum logic [2:0] {
    ST_CMD, ST_WRITE, ST_FETCH, ST_READ, ST_HOLD
  } seq_state_t;

  typedef struct packed {
    logic [15:0]      addr;
    logic [3:0]       opc;
    logic             inc;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       spare;
  } cmd_t;
endpackage

// File: rtl/spib_sync.sv
module spib_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spib_rx.sv
module spib_rx
  import spib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  output logic              fall,
  output logic              word_ok,
  output logic [WORD_W-1:0] word
);
  localparam int BC_W = $clog2(WORD_W);

  logic              sclk_d;
  logic              rise;
  logic [WORD_W-2:0] shreg_q;
  logic [BC_W-1:0]   bit_cnt;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign word_ok = rise && !cs_n_s && (bit_cnt == BC_W'(WORD_W-1));
  assign word    = {shreg_q, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      shreg_q <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg_q <= {shreg_q[WORD_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R8: a deselect always leaves the bit counter cleared
  assert_bitcnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_s) |-> bit_cnt == '0);
endmodule

// File: rtl/spib_seq.sv
module spib_seq
  import spib_pkg::*;
#(
  parameter logic [15:0] ADDR_STEP = 16'd4,
  parameter logic [15:0] ID_ADDR   = 16'hFF00,
  parameter logic [31:0] ID_WORD   = 32'h4B1D_E2A7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              fall,
  input  logic              word_ok,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [15:0]       bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              miso
);
  seq_state_t        state_q;
  cmd_t              cmd;
  logic [15:0]       addr_q;
  logic              inc_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] wdata_q;
  logic              wr_q;
  logic              miso_q;

  assign cmd       = cmd_t'(word);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_wr    = wr_q;
  assign bus_rd    = (state_q == ST_FETCH) && (addr_q != ID_ADDR);
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      addr_q  <= '0;
      inc_q   <= 1'b0;
      left_q  <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (wr_q && inc_q) addr_q <= addr_q + ADDR_STEP;
      if (cs_n_s) begin
        state_q <= ST_CMD;
        left_q  <= '0;
        miso_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CMD: if (word_ok) begin
            addr_q <= cmd.addr;
            inc_q  <= cmd.inc;
            left_q <= cmd.cnt;
            if (cmd.cnt == '0)              state_q <= ST_HOLD;
            else if (cmd.opc == OPC_READ)   state_q <= ST_FETCH;
            else if (cmd.opc == OPC_WRITE)  state_q <= ST_WRITE;
            else                            state_q <= ST_HOLD;
          end
          ST_WRITE: if (word_ok) begin
            wr_q    <= 1'b1;
            wdata_q <= word;
            left_q  <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) state_q <= ST_HOLD;
          end
          ST_FETCH: begin
            tx_q    <= (addr_q == ID_ADDR) ? ID_WORD : bus_rdata;
            left_q  <= left_q - 1'b1;
            if (inc_q) addr_q <= addr_q + ADDR_STEP;
            state_q <= ST_READ;
          end
          ST_READ: begin
            if (fall) begin
              miso_q <= tx_q[WORD_W-1];
              tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
            end
            if (word_ok) state_q <= (left_q != '0) ? ST_FETCH : ST_HOLD;
          end
          default: if (fall) miso_q <= 1'b0;
        endcase
      end
    end
  end

  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> (!bus_wr && !bus_rd && !miso));
  assert_miso_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_q != $past(miso_q)) |-> ($past(fall) || $past(cs_n_s)));
  assert_fetch_before_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> state_q != ST_FETCH);
  assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> !bus_wr);
endmodule

// File: rtl/spi_regbus_bridge.sv
module spi_regbus_bridge
  import spib_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ADDR_STEP   = 16'd4,
  parameter logic [15:0] ID_ADDR     = 16'hFF00,
  parameter logic [31:0] ID_WORD     = 32'h4B1D_E2A7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd,
  input  logic [31:0] bus_rdata
);
  logic [2:0]        pins_s;
  logic              fall, word_ok;
  logic [WORD_W-1:0] word;

  spib_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_cs_n, spi_sclk, spi_mosi}), .dout(pins_s));

  spib_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .mosi_s(pins_s[0]), .cs_n_s(pins_s[2]),
    .fall(fall), .word_ok(word_ok), .word(word));

  spib_seq #(.ADDR_STEP(ADDR_STEP), .ID_ADDR(ID_ADDR), .ID_WORD(ID_WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[2]),
    .fall(fall), .word_ok(word_ok), .word(word), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .miso(spi_miso));
endmodule

// File: tb/test_spi_regbus_bridge.sv
module test_spi_regbus_bridge;
  localparam logic [15:0] ID_ADDR = 16'hFF00;
  localparam logic [31:0] ID_WORD = 32'h4B1D_E2A7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  spi_regbus_bridge i_spi_regbus_bridge (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata));

  logic [31:0] mem    [0:63];
  logic [31:0] shadow [0:63];
  logic [31:0] tx_buf [0:128];
  logic [31:0] rx_buf [0:128];
  logic [47:0] exp_wr [$];
  int n_chk = 0, n_fail = 0, rd_seen = 0;
  bit done = 0;

  assign bus_rdata = mem[bus_addr[7:2]];
  always @(posedge clk) if (bus_wr) mem[bus_addr[7:2]] <= bus_wdata;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write monitor: pops the scoreboard on each strobe (R3, R4, R6)
  always @(negedge clk) begin
    if (rst_n && bus_rd) rd_seen++;
    if (rst_n && bus_wr) begin
      if (exp_wr.size() == 0) chk(0, "R6 unexpected write", {bus_addr, bus_wdata}, 48'h0);
      else begin
        logic [47:0] e;
        e = exp_wr.pop_front();
        chk({bus_addr, bus_wdata} == e, "R3/R4 write", {bus_addr, bus_wdata}, e);
      end
    end
  end

  function automatic logic [31:0] mk_cmd(input logic [15:0] a, input logic [3:0] op,
                                         input bit inc, input int cnt);
    return {a, op, inc, 7'(cnt), 4'h9};  // R2: low nibble set, must be ignored
  endfunction

  task automatic frame(input int nwords, input int extra_bits);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int w = 0; w < nwords; w++)
      for (int b = 31; b >= 0; b--) begin
        mosi = tx_buf[w][b];
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        rx_buf[w][b] = miso;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
      end
    for (int k = 0; k < extra_bits; k++) begin
      mosi = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a0, input bit inc, input int cnt, input int nsent);
    logic [15:0] a;
    a = a0;
    tx_buf[0] = mk_cmd(a0, 4'hB, inc, cnt);
    for (int i = 0; i < nsent; i++) begin
      tx_buf[i+1] = 32'h1357_0000 + {a0, 16'h0} + 32'(i * 32'h0101_0101);
      if (i < cnt) begin
        exp_wr.push_back({a, tx_buf[i+1]});
        shadow[a[7:2]] = tx_buf[i+1];
        if (inc) a = a + 16'd4;
      end
    end
    frame(nsent + 1, 0);
  endtask

  task automatic do_read(input logic [15:0] a0, input bit inc, input int cnt,
                         input int nsent, input string req);
    logic [15:0] a;
    logic [31:0] e;
    int rd0, nbus;
    a = a0; rd0 = rd_seen; nbus = 0;
    tx_buf[0] = mk_cmd(a0, 4'hA, inc, cnt);
    for (int i = 0; i < nsent; i++) tx_buf[i+1] = 32'hFFFF_FFFF;
    frame(nsent + 1, 0);
    for (int i = 0; i < nsent; i++) begin
      if (i < cnt) begin
        e = (a == ID_ADDR) ? ID_WORD : shadow[a[7:2]];
        if (a != ID_ADDR) nbus++;
        if (inc) a = a + 16'd4;
      end else e = 32'h0;
      chk(rx_buf[i+1] == e, req, 48'(rx_buf[i+1]), 48'(e));
    end
    chk(rd_seen - rd0 == nbus, "R10 read strobe count", 48'(rd_seen - rd0), 48'(nbus));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'hC0DE_0000 + 32'(i * 7);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(miso == 1'b0 && !bus_wr && !bus_rd, "R1 reset outputs", {45'h0, miso, bus_wr, bus_rd}, 48'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(miso == 1'b0 && !bus_wr && !bus_rd, "R1 idle outputs", {45'h0, miso, bus_wr, bus_rd}, 48'h0);

    do_write(16'h0010, 1, 3, 3);                    // R2 R3 R4
    do_read (16'h0010, 1, 3, 3, "R5 burst read");   // R5 R10
    do_write(16'h0020, 0, 2, 2);                    // R4 no increment
    do_read (16'h0020, 0, 1, 1, "R4 fixed-address write result");
    do_read (16'h0010, 0, 2, 2, "R4 fixed-address read");
    do_write(16'h0030, 1, 1, 3);                    // R6 surplus write words
    do_read (16'h0030, 1, 1, 3, "R6 surplus read words");
    do_write(16'h0034, 1, 0, 1);                    // R6 zero count

    // R7: unknown opcode with data words
    begin
      int rd0;
      rd0 = rd_seen;
      tx_buf[0] = mk_cmd(16'h0010, 4'h5, 1, 2);
      tx_buf[1] = 32'hDEAD_BEEF; tx_buf[2] = 32'hFEED_F00D;
      frame(3, 0);
      chk(rx_buf[1] == 0 && rx_buf[2] == 0, "R7 miso quiet", 48'(rx_buf[1] | rx_buf[2]), 48'h0);
      chk(rd_seen == rd0, "R7 no read strobe", 48'(rd_seen), 48'(rd0));
    end

    // R8: partial frame aborted, then a clean write
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      mosi = k[0];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (10) @(negedge clk);
    do_write(16'h0040, 1, 2, 2);                    // R8 fresh command
    do_read (16'h0040, 1, 2, 2, "R8 after abort");

    do_read(ID_ADDR, 0, 1, 1, "R9 identification word");
    do_read(ID_ADDR, 0, 127, 128, "R6 maximum count");

    chk(exp_wr.size() == 0, "R3 all writes seen", 48'(exp_wr.size()), 48'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule